// File: doc/BRIEF.md
# Vector Register Redirection Table Loader

This block keeps a small set of configuration words, each describing how one architectural register is to be remapped when it is used as a vector operand. Software writes the words through a simple register-write port. Asserting the setup request then rebuilds two per-register lookup tables from these words. One table holds 32 slots for integer registers and the other holds 32 slots for floating-point registers.

A rebuild runs in two phases. First, every slot in both tables is cleared. Then the configuration words are applied one at a time, lowest index first. Each word lands in the table named by its class bit, in the slot named by its key register.

Decode logic queries the tables through a combinational port. It gives a register class and a 5-bit register number, and gets back four fields: the real starting register, the element-width code, the vector flag and the packed-SIMD flag. A slot whose vector flag is 0 means the register is an ordinary scalar with no redirection.

Top module: `vrr_loader`

## Requirements
- R1: A write with `cfg_we`=1 stores `cfg_wdata` into configuration word `cfg_addr` (0..15). The word layout is: bit 0 = class (0 integer, 1 floating-point), bits 5:1 = key register, bits 10:6 = target start register, bits 12:11 = element-width code, bit 13 = vector flag, bit 14 = packed-SIMD flag, bit 15 = bank.
- R2: The element-width code is stored and returned unchanged. Its meaning is: 0 = default width, 1 = half of default, 2 = 8 bits, 3 = 16 bits.
- R3: Every setup first zeroes all 32 integer slots and all 32 floating-point slots. A slot that no word targets in this setup therefore reads all-zero afterwards, whatever it held before.
- R4: Setup applies words 0 to 15 in order. A word with class 0 goes to the integer table and a word with class 1 goes to the floating-point table, at the slot equal to its key. The other table is left unchanged.
- R5: When two words share the same class and key, the higher-numbered word determines the slot.
- R6: `setup_req` is sampled while the block is idle. `busy` is 1 for exactly 17 cycles, starting with the cycle after the sampling edge. `done` is 1 for the single cycle that follows, and `busy` and `done` are never 1 together.
- R7: While `busy` is 1, the lookup outputs are all zero (scalar, unmapped).
- R8: A word whose bank bit is 1 is reserved and is skipped by setup. Its target slot keeps the cleared value unless another word writes that slot.
- R9: A configuration write while `busy` is 1 is ignored.
- R10: After reset, `busy` and `done` are 0, every slot reads zero, and every configuration word is zero.
- R11: A slot whose vector flag is 0 is returned exactly as written, with its other fields intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 16 | Configuration word value |
| setup_req | input | 1 | Starts a table rebuild when idle |
| busy | output | 1 | Rebuild in progress |
| done | output | 1 | One-cycle pulse after a rebuild completes |
| lk_fp | input | 1 | Lookup class: 0 integer, 1 floating-point |
| lk_reg | input | 5 | Lookup register number |
| lk_target | output | 5 | Real starting register |
| lk_width | output | 2 | Element-width code |
| lk_vec | output | 1 | Vector flag |
| lk_simd | output | 1 | Packed-SIMD flag |

## Verification
A configuration write takes effect at the next clock edge. The only way it becomes visible, however, is through a later rebuild. The bench therefore checks writes only through lookups made after `done`.

`busy` is due one edge after `setup_req` is sampled, and stays up for 17 edges. `done` follows on the edge after that. The bench counts the busy cycles on falling edges and checks `done` at the first falling edge where `busy` is 0.

Lookups are combinational. The bench changes the class and register number on a falling edge and compares the outputs a quarter period later, with no clock edge in between.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int REGS      = 32;
  localparam int REG_IDX_W = $clog2(REGS);
  localparam int WIDTH_W   = 2;

  // Configuration word, LSB first: class, key, target, width, vec, simd, bank
  typedef struct packed {
    logic                 bank;
    logic                 simd;
    logic                 vec;
    logic [WIDTH_W-1:0]   width;
    logic [REG_IDX_W-1:0] target;
    logic [REG_IDX_W-1:0] key;
    logic                 fp;
  } cfg_word_t;

  // One slot of a lookup table
  typedef struct packed {
    logic [REG_IDX_W-1:0] target;
    logic [WIDTH_W-1:0]   width;
    logic                 vec;
    logic                 simd;
  } map_slot_t;

  localparam int CFG_W  = $bits(cfg_word_t);
  localparam int SLOT_W = $bits(map_slot_t);
endpackage

// File: rtl/vrr_cfg_store.sv
module vrr_cfg_store
  import vrr_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             lock,
  input  logic [IDX_W-1:0] wr_idx,
  input  cfg_word_t        wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output cfg_word_t        rd_word
);
  cfg_word_t [ENTRIES-1:0] mem_q;
  cfg_word_t [ENTRIES-1:0] mem_d;
  logic                    mem_en;

  assign mem_en = wr_en && !lock;

  always_comb begin
    mem_d = mem_q;
    if (mem_en) mem_d[wr_idx] = wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  assign rd_word = mem_q[rd_idx];

  // R9: a write during a rebuild leaves every configuration word untouched
  a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> $stable(mem_q));
endmodule

// File: rtl/vrr_setup_seq.sv
module vrr_setup_seq #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             clr,
  output logic             apply,
  output logic [IDX_W-1:0] idx
);
  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_WALK, S_FIN} state_t;

  state_t           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_CLEAR;
      S_CLEAR: begin
        state_d = S_WALK;
        idx_d   = '0;
      end
      S_WALK: begin
        if (idx_q == LAST) state_d = S_FIN;
        else               idx_d   = idx_q + 1'b1;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy  = (state_q == S_CLEAR) || (state_q == S_WALK);
  assign done  = (state_q == S_FIN);
  assign clr   = (state_q == S_CLEAR);
  assign apply = (state_q == S_WALK);
  assign idx   = idx_q;

  // R6: a request seen while idle starts the rebuild on the next cycle
  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start) |=> busy);
  // R6: completion is flagged only right after a busy cycle
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  // R6: busy and done never overlap
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R4: entries are visited in ascending order
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && idx_q != LAST) |=> (apply && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/vrr_map_table.sv
module vrr_map_table
  import vrr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] waddr,
  input  map_slot_t            wdata,
  input  logic [REG_IDX_W-1:0] raddr,
  output map_slot_t            rdata
);
  map_slot_t [REGS-1:0] slot_q;
  map_slot_t [REGS-1:0] slot_d;
  logic                 slot_en;

  assign slot_en = clr || we;

  always_comb begin
    slot_d = slot_q;
    if (clr)     slot_d = '0;
    else if (we) slot_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else if (slot_en) slot_q <= slot_d;
  end

  assign rdata = slot_q[raddr];

  // R3: a clear cycle leaves every slot zero
  a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (slot_q == '0));
  // R4: a write lands exactly the given slot contents at the given index
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (slot_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/vrr_loader.sv
module vrr_loader
  import vrr_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 setup_req,
  output logic                 busy,
  output logic                 done,
  input  logic                 lk_fp,
  input  logic [REG_IDX_W-1:0] lk_reg,
  output logic [REG_IDX_W-1:0] lk_target,
  output logic [WIDTH_W-1:0]   lk_width,
  output logic                 lk_vec,
  output logic                 lk_simd
);
  localparam int CLASSES = 2;

  logic             clr, apply;
  logic [IDX_W-1:0] walk_idx;
  cfg_word_t        cur_word;
  map_slot_t        cur_slot;
  map_slot_t        tbl_rd  [CLASSES];
  map_slot_t        lk_slot;
  logic             take;

  vrr_setup_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (setup_req),
    .busy  (busy),
    .done  (done),
    .clr   (clr),
    .apply (apply),
    .idx   (walk_idx)
  );

  vrr_cfg_store #(.ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .lock    (busy),
    .wr_idx  (cfg_addr),
    .wr_word (cfg_word_t'(cfg_wdata)),
    .rd_idx  (walk_idx),
    .rd_word (cur_word)
  );

  // Reserved bank value: entry is not applied
  assign take = apply && !cur_word.bank;

  assign cur_slot = '{target: cur_word.target, width: cur_word.width,
                      vec: cur_word.vec, simd: cur_word.simd};

  for (genvar c = 0; c < CLASSES; c++) begin : g_tbl
    vrr_map_table u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .we    (take && (cur_word.fp == 1'(c))),
      .waddr (cur_word.key),
      .wdata (cur_slot),
      .raddr (lk_reg),
      .rdata (tbl_rd[c])
    );
  end

  always_comb begin
    lk_slot = tbl_rd[lk_fp];
    if (busy) lk_slot = '0;
  end

  assign lk_target = lk_slot.target;
  assign lk_width  = lk_slot.width;
  assign lk_vec    = lk_slot.vec;
  assign lk_simd   = lk_slot.simd;

  // R8: a reserved-bank entry never reaches either table
  a_r8_bank_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cur_word.bank) |-> !(g_tbl[0].u_tbl.we || g_tbl[1].u_tbl.we));
  // R10: nothing is in progress right after reset
  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done));
endmodule

// File: tb/vrr_loader_tb.sv
module vrr_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        setup_req;
  logic        busy, done;
  logic        lk_fp;
  logic [4:0]  lk_reg;
  logic [4:0]  lk_target;
  logic [1:0]  lk_width;
  logic        lk_vec, lk_simd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vrr_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .setup_req(setup_req), .busy(busy), .done(done),
    .lk_fp(lk_fp), .lk_reg(lk_reg), .lk_target(lk_target),
    .lk_width(lk_width), .lk_vec(lk_vec), .lk_simd(lk_simd)
  );

  // Word layout {bank, simd, vec, width, target, key, class}
  localparam logic [15:0] CFG [16] = '{
    {1'b0, 1'b0, 1'b1, 2'd0, 5'd8,  5'd1,  1'b0},
    {1'b0, 1'b1, 1'b1, 2'd2, 5'd16, 5'd1,  1'b1},
    {1'b0, 1'b1, 1'b1, 2'd3, 5'd20, 5'd5,  1'b0},
    {1'b0, 1'b0, 1'b1, 2'd1, 5'd9,  5'd1,  1'b0},
    {1'b0, 1'b0, 1'b1, 2'd2, 5'd30, 5'd31, 1'b0},
    {1'b0, 1'b1, 1'b0, 2'd1, 5'd4,  5'd0,  1'b1},
    {1'b1, 1'b0, 1'b1, 2'd0, 5'd12, 5'd7,  1'b0},
    {1'b0, 1'b1, 1'b1, 2'd3, 5'd31, 5'd31, 1'b1},
    {1'b0, 1'b1, 1'b1, 2'd2, 5'd2,  5'd10, 1'b0},
    16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0
  };

  // Lookup vectors {class, reg, expected {target, width, vec, simd}}
  localparam logic [14:0] VEC [11] = '{
    {1'b0, 5'd1,  5'd9,  2'd1, 1'b1, 1'b0},
    {1'b1, 5'd1,  5'd16, 2'd2, 1'b1, 1'b1},
    {1'b0, 5'd5,  5'd20, 2'd3, 1'b1, 1'b1},
    {1'b0, 5'd31, 5'd30, 2'd2, 1'b1, 1'b0},
    {1'b1, 5'd0,  5'd4,  2'd1, 1'b0, 1'b1},
    {1'b0, 5'd7,  9'd0},
    {1'b1, 5'd31, 5'd31, 2'd3, 1'b1, 1'b1},
    {1'b0, 5'd10, 5'd2,  2'd2, 1'b1, 1'b1},
    {1'b1, 5'd5,  9'd0},
    {1'b0, 5'd2,  9'd0},
    {1'b1, 5'd10, 9'd0}
  };
  localparam string VEC_REQ [11] = '{"R5", "R4", "R2", "R4", "R11", "R8",
                                     "R2", "R4", "R4", "R3", "R3"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [8:0] lk_value();
    return {lk_target, lk_width, lk_vec, lk_simd};
  endfunction

  task automatic look(input logic fp, input logic [4:0] r);
    lk_fp = fp; lk_reg = r;
    #1.25;
  endtask

  // Starts a rebuild and checks busy length and done pulse (R6)
  task automatic run_setup(input bit poke_busy);
    int n;
    @(negedge clk);
    setup_req = 1'b1;
    @(negedge clk);
    setup_req = 1'b0;
    n = 0;
    while (busy && n < 40) begin
      if (n == 3) begin
        look(1'b1, 5'd1);
        check("R7", lk_value(), 9'd0);  // R7: zero while busy
        if (poke_busy) begin
          cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 16'h0;
        end
      end
      @(negedge clk);
      cfg_we = 1'b0;
      n++;
    end
    check("R6 busy cycles", n, 17);
    check("R6 done pulse", done, 1'b1);
    @(negedge clk);
    check("R6 done one cycle", done, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    setup_req = 1'b0; lk_fp = 1'b0; lk_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 busy", busy, 1'b0);
    check("R10 done", done, 1'b0);
    look(1'b0, 5'd1);
    check("R10 int slot", lk_value(), 9'd0);
    look(1'b1, 5'd31);
    check("R10 fp slot", lk_value(), 9'd0);

    // R1: load words, rebuild, walk vector table
    for (int i = 0; i < 16; i++) write_cfg(4'(i), CFG[i]);
    run_setup(1'b0);
    for (int i = 0; i < 11; i++) begin
      look(VEC[i][14], VEC[i][13:9]);
      check($sformatf("%s/R1 vec %0d", VEC_REQ[i], i), lk_value(), VEC[i][8:0]);
    end

    // R3: second rebuild clears earlier mappings; R9: write while busy ignored
    write_cfg(4'd0, 16'h0);
    write_cfg(4'd3, {1'b0, 1'b0, 1'b1, 2'd0, 5'd3, 5'd2, 1'b0});
    run_setup(1'b1);
    look(1'b0, 5'd1);
    check("R3 stale slot cleared", lk_value(), 9'd0);
    look(1'b0, 5'd2);
    check("R4 new slot", lk_value(), {5'd3, 2'd0, 1'b1, 1'b0});
    look(1'b0, 5'd10);
    check("R9 busy write ignored", lk_value(), {5'd2, 2'd2, 1'b1, 1'b1});

    // R9: a later rebuild still uses the unchanged word 8
    run_setup(1'b0);
    look(1'b0, 5'd10);
    check("R9 word kept", lk_value(), {5'd2, 2'd2, 1'b1, 1'b1});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule